// File: doc/BRIEF.md
# Serial Port Buffer and Status Flag Unit

This unit sits between a simple register bus and the bit-level engine of a serial port. On the send side it keeps a single holding register that hands its byte to the shifter as soon as the shifter falls idle. On the receive side it keeps a single byte that a completed frame fills and a bus read empties. Bit timing is not modelled here: strobes tell the unit when a frame has finished shifting out and when one has arrived, and the raw receive line is watched only for edges.

From that traffic the unit derives a status byte of interrupt flags, each with its own set and clear rule. Some follow the data, such as buffer occupancy. Some are set by an event and cleared only by writing a one to their bit. One is set by a falling edge on the receive line while the device is in standby sleep. A single request line is raised whenever any flag is set and its enable bit is high.

Top module: `sbs_serial_flags`

## Requirements
- R1: After reset `status` reads 0x20: only the empty-holding-register bit (bit 5) is 1.
- R2: Bit 7 is 1 from the cycle after a frame arrives while the receiver is enabled. It goes to 0 the cycle after a bus read, unless a new frame arrives in that same cycle. `rx_rdata` presents the last byte taken in.
- R3: While `rx_enable` is low the receive byte is discarded. Bit 7 reads 0 from the next cycle on, and frames arriving in that time are ignored.
- R4: Bit 5 is 1 while the holding register is empty. A `tx_wr` clears it at the next edge, and it returns to 1 at the edge where the byte moves to the shifter.
- R5: The byte moves on the first edge at which the holding register is full and `shift_busy` is 0. `shift_load` is high in the cycle before that edge, with the byte on `shift_data`, and `shift_busy` is 1 after it. A `tx_frame_done` while busy makes `shift_busy` 0 at the next edge.
- R6: Bit 6 becomes 1 when a frame finishes while the holding register is empty and no write is arriving. It stays 0 if a byte is waiting. Writing 1 to bit 6 clears it.
- R7: A status write never changes bits 5 and 7. Bits 2 and 0 always read 0.
- R8: Bit 4 is set by a falling edge on `rxd`, seen after the input synchronizer, while `standby` and `start_det_en` are both high. Writing 1 to bit 4 clears it. It reads 0, and is cleared, whenever `start_det_en` is low.
- R9: A `sync_err` pulse sets bit 3, and writing 1 to bit 3 clears it.
- R10: A `brk_det` pulse sets bit 1. Writing 1 to bit 1, or the next frame accepted by the receiver, clears it. A set wins over a clear in the same cycle; the same holds for bits 3, 4 and 6.
- R11: Writing 1 to bit 0 arms a break wait. The next synchronized low followed by a rise on `rxd` then sets bit 1.
- R12: `irq` is high exactly when `status & irq_en` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receiver enable; low flushes the receive byte |
| standby | input | 1 | Device is in standby sleep |
| start_det_en | input | 1 | Enables start-edge detection during sleep |
| tx_wr | input | 1 | Write strobe for the transmit data byte |
| tx_wdata | input | DATA_W | Transmit data |
| rx_rd | input | 1 | Read strobe for the receive byte |
| rx_rdata | output | DATA_W | Receive byte |
| stat_wr | input | 1 | Status write strobe (write one to clear) |
| stat_wdata | input | 8 | Status write data |
| tx_frame_done | input | 1 | Shifter has sent its whole frame |
| rx_frame_done | input | 1 | A frame has been received |
| rx_frame_data | input | DATA_W | Data of the received frame |
| rxd | input | 1 | Raw receive line, idle high |
| sync_err | input | 1 | Sync-field error event |
| brk_det | input | 1 | Break-detected event |
| irq_en | input | 8 | Per-bit interrupt enables |
| status | output | 8 | Status flags |
| irq | output | 1 | Interrupt request |
| shift_load | output | 1 | Holding register moves to the shifter at the next edge |
| shift_data | output | DATA_W | Byte in the holding register |
| shift_busy | output | 1 | Shifter holds a frame |

## Verification
The bench builds the unit with DATA_W = 8 and SYNC_STAGES = 3. Three synchronizer stages lengthen the path from a line edge to bit 4 and to the break-wait state machine past the default. This exercises the generated stage chain and shows that the reference model follows the extra latency. Random bursts of writes, reads, frame strobes and line toggles reach the collisions the requirements order: a write meeting a transfer, a read meeting a new frame, and a set meeting a write-one clear.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int STAT_W = 8;

    // Status bit positions (software decodes these)
    localparam int B_RXC = 7;
    localparam int B_TXC = 6;
    localparam int B_DRE = 5;
    localparam int B_RXS = 4;
    localparam int B_SFE = 3;
    localparam int B_RSV = 2;
    localparam int B_BDF = 1;
    localparam int B_WFB = 0;

    typedef struct packed {
        logic rxc;
        logic txc;
        logic dre;
        logic rxs;
        logic sfe;
        logic bdf;
    } flags_t;

    typedef enum logic [1:0] {
        WB_IDLE  = 2'd0,
        WB_ARMED = 2'd1,
        WB_LOW   = 2'd2
    } wfb_state_e;

    function automatic logic [STAT_W-1:0] pack_status(flags_t f);
        logic [STAT_W-1:0] s;
        s        = '0;
        s[B_RXC] = f.rxc;
        s[B_TXC] = f.txc;
        s[B_DRE] = f.dre;
        s[B_RXS] = f.rxs;
        s[B_SFE] = f.sfe;
        s[B_BDF] = f.bdf;
        return s;
    endfunction

    function automatic logic w1c_hit(logic wr, logic [STAT_W-1:0] d, int b);
        return wr && d[b];
    endfunction

endpackage

// File: rtl/sbs_tx_path.sv
module sbs_tx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txd_wr,
    input  logic [DATA_W-1:0] txd_wdata,
    input  logic              tx_frame_done,
    input  logic              clr_txc,
    output logic              dre,
    output logic              txc,
    output logic              sh_load,
    output logic [DATA_W-1:0] sh_data,
    output logic              sh_busy
);
    logic              buf_v;
    logic [DATA_W-1:0] buf_d;
    logic              busy_q;
    logic              txc_q;
    logic              xfer;
    logic              frame_end;

    assign xfer      = buf_v && !busy_q;
    assign frame_end = tx_frame_done && busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_v  <= 1'b0;
            buf_d  <= '0;
            busy_q <= 1'b0;
            txc_q  <= 1'b0;
        end else begin
            // holding register: a new write wins over the handoff
            if (txd_wr) begin
                buf_v <= 1'b1;
                buf_d <= txd_wdata;
            end else if (xfer) begin
                buf_v <= 1'b0;
            end
            // shifter occupancy
            if (xfer)
                busy_q <= 1'b1;
            else if (frame_end)
                busy_q <= 1'b0;
            // transmit complete: set beats clear
            if (frame_end && !buf_v && !txd_wr)
                txc_q <= 1'b1;
            else if (clr_txc)
                txc_q <= 1'b0;
        end
    end

    assign dre     = !buf_v;
    assign txc     = txc_q;
    assign sh_load = xfer;
    assign sh_data = buf_d;
    assign sh_busy = busy_q;

    assert_dre_clear_R4: assert property (@(posedge clk) disable iff (rst)
        txd_wr |=> !dre);

    assert_load_busy_R5: assert property (@(posedge clk) disable iff (rst)
        sh_load |=> sh_busy);

    assert_txc_empty_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(txc_q) |-> $past(!buf_v && busy_q && tx_frame_done));

endmodule

// File: rtl/sbs_rx_path.sv
module sbs_rx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              rx_frame_done,
    input  logic [DATA_W-1:0] rx_frame_data,
    input  logic              rxd_rd,
    input  logic              brk_set,
    input  logic              clr_bdf,
    output logic              rxc,
    output logic [DATA_W-1:0] rdata,
    output logic              bdf
);
    logic              rb_v;
    logic [DATA_W-1:0] rb_d;
    logic              bdf_q;
    logic              accept;

    assign accept = rx_en && rx_frame_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_v  <= 1'b0;
            rb_d  <= '0;
            bdf_q <= 1'b0;
        end else begin
            // receive byte: disable flushes, new frame beats a read
            if (!rx_en)
                rb_v <= 1'b0;
            else if (rx_frame_done)
                rb_v <= 1'b1;
            else if (rxd_rd)
                rb_v <= 1'b0;
            if (accept)
                rb_d <= rx_frame_data;
            // break flag: set beats both clear sources
            if (brk_set)
                bdf_q <= 1'b1;
            else if (clr_bdf || accept)
                bdf_q <= 1'b0;
        end
    end

    assign rxc   = rb_v;
    assign rdata = rb_d;
    assign bdf   = bdf_q;

    assert_flush_R3: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !rxc);

    assert_rxc_source_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(rb_v) |-> $past(rx_frame_done && rx_en));

    assert_bdf_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (accept && !brk_set) |=> !bdf);

endmodule

// File: rtl/sbs_line_mon.sv
module sbs_line_mon
    import sbs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd_line,
    input  logic sleep_i,
    input  logic sdet_en,
    input  logic clr_rxs,
    input  logic arm_wfb,
    output logic rxs,
    output logic brk_pulse
);
    logic [SYNC_STAGES:0] chain;
    logic                 prev_q;
    logic                 line_s;
    logic                 fall;
    logic                 rise;
    logic                 rxs_q;
    wfb_state_e           st_q;
    wfb_state_e           st_d;

    assign chain[0] = rxd_line;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        logic st_ff;
        always_ff @(posedge clk) begin
            if (rst) st_ff <= 1'b1;
            else     st_ff <= chain[i];
        end
        assign chain[i+1] = st_ff;
    end

    assign line_s = chain[SYNC_STAGES];
    assign fall   = prev_q && !line_s;
    assign rise   = !prev_q && line_s;

    always_comb begin
        st_d = st_q;
        if (arm_wfb) begin
            st_d = WB_ARMED;
        end else begin
            case (st_q)
                WB_ARMED: if (!line_s) st_d = WB_LOW;
                WB_LOW:   if (rise)    st_d = WB_IDLE;
                default:  st_d = WB_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            rxs_q  <= 1'b0;
            st_q   <= WB_IDLE;
        end else begin
            prev_q <= line_s;
            st_q   <= st_d;
            if (!sdet_en)
                rxs_q <= 1'b0;
            else if (sleep_i && fall)
                rxs_q <= 1'b1;
            else if (clr_rxs)
                rxs_q <= 1'b0;
        end
    end

    assign rxs       = rxs_q && sdet_en;
    assign brk_pulse = (st_q == WB_LOW) && rise;

    assert_rxs_sleep_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rxs_q) |-> $past(sleep_i && sdet_en));

    assert_wfb_armed_R11: assert property (@(posedge clk) disable iff (rst)
        arm_wfb |=> (st_q == WB_ARMED));

endmodule

// File: rtl/sbs_serial_flags.sv
module sbs_serial_flags
    import sbs_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_enable,
    input  logic              standby,
    input  logic              start_det_en,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              tx_frame_done,
    input  logic              rx_frame_done,
    input  logic [DATA_W-1:0] rx_frame_data,
    input  logic              rxd,
    input  logic              sync_err,
    input  logic              brk_det,
    input  logic [STAT_W-1:0] irq_en,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic              shift_load,
    output logic [DATA_W-1:0] shift_data,
    output logic              shift_busy
);
    flags_t fl;
    logic   clr_txc, clr_rxs, clr_sfe, clr_bdf, arm_wfb;
    logic   sfe_q;
    logic   wfb_brk;
    logic   unused_wbits;

    assign clr_txc = w1c_hit(stat_wr, stat_wdata, B_TXC);
    assign clr_rxs = w1c_hit(stat_wr, stat_wdata, B_RXS);
    assign clr_sfe = w1c_hit(stat_wr, stat_wdata, B_SFE);
    assign clr_bdf = w1c_hit(stat_wr, stat_wdata, B_BDF);
    assign arm_wfb = w1c_hit(stat_wr, stat_wdata, B_WFB);
    // read-only and reserved positions take no write
    assign unused_wbits = ^{stat_wdata[B_RXC], stat_wdata[B_DRE], stat_wdata[B_RSV]};

    sbs_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk           (clk),
        .rst           (rst),
        .txd_wr        (tx_wr),
        .txd_wdata     (tx_wdata),
        .tx_frame_done (tx_frame_done),
        .clr_txc       (clr_txc),
        .dre           (fl.dre),
        .txc           (fl.txc),
        .sh_load       (shift_load),
        .sh_data       (shift_data),
        .sh_busy       (shift_busy)
    );

    sbs_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk           (clk),
        .rst           (rst),
        .rx_en         (rx_enable),
        .rx_frame_done (rx_frame_done),
        .rx_frame_data (rx_frame_data),
        .rxd_rd        (rx_rd),
        .brk_set       (brk_det || wfb_brk),
        .clr_bdf       (clr_bdf),
        .rxc           (fl.rxc),
        .rdata         (rx_rdata),
        .bdf           (fl.bdf)
    );

    sbs_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst       (rst),
        .rxd_line  (rxd),
        .sleep_i   (standby),
        .sdet_en   (start_det_en),
        .clr_rxs   (clr_rxs),
        .arm_wfb   (arm_wfb),
        .rxs       (fl.rxs),
        .brk_pulse (wfb_brk)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sfe_q <= 1'b0;
        else if (sync_err)
            sfe_q <= 1'b1;
        else if (clr_sfe)
            sfe_q <= 1'b0;
    end

    assign fl.sfe = sfe_q;
    assign status = pack_status(fl);
    assign irq    = |(status & irq_en);

    assert_sfe_set_R9: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> status[B_SFE]);

    assert_wfb_sets_bdf_R11: assert property (@(posedge clk) disable iff (rst)
        wfb_brk |=> status[B_BDF]);

    assert_dre_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !tx_wr && !shift_load) |=> $stable(status[B_DRE]));

endmodule

// File: tb/sbs_serial_flags_bench.sv
module sbs_serial_flags_bench;
    localparam int DW   = 8;
    localparam int SYNC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          i_rxen = 1'b1, i_sleep = 1'b0, i_sdet = 1'b1;
    logic          i_txwr = 1'b0, i_rd = 1'b0, i_swr = 1'b0;
    logic [DW-1:0] i_txd = '0, i_rxdat = '0;
    logic [7:0]    i_swd = '0, i_ien = '0;
    logic          i_txdone = 1'b0, i_rxdone = 1'b0, i_rxd = 1'b1;
    logic          i_serr = 1'b0, i_brk = 1'b0;
    logic [DW-1:0] o_rdata, o_shd;
    logic [7:0]    o_stat;
    logic          o_irq, o_load, o_busy;

    int vectors = 0;
    int miscmp  = 0;
    bit done    = 0;

    // reference model state
    logic          m_tbv, m_busy, m_txc, m_rbv, m_bdf, m_sfe, m_rxs, m_prev;
    logic [DW-1:0] m_tbd, m_rbd;
    logic [SYNC-1:0] m_sync;
    int            m_wst;

    always #10 clk = ~clk;

    sbs_serial_flags #(.DATA_W(DW), .SYNC_STAGES(SYNC)) u_sbs_serial_flags (
        .clk(clk), .rst(rst), .rx_enable(i_rxen), .standby(i_sleep),
        .start_det_en(i_sdet), .tx_wr(i_txwr), .tx_wdata(i_txd), .rx_rd(i_rd),
        .rx_rdata(o_rdata), .stat_wr(i_swr), .stat_wdata(i_swd),
        .tx_frame_done(i_txdone), .rx_frame_done(i_rxdone),
        .rx_frame_data(i_rxdat), .rxd(i_rxd), .sync_err(i_serr), .brk_det(i_brk),
        .irq_en(i_ien), .status(o_stat), .irq(o_irq), .shift_load(o_load),
        .shift_data(o_shd), .shift_busy(o_busy)
    );

    function automatic logic [7:0] exp_status();
        return {m_rbv, m_txc, !m_tbv, m_rxs && i_sdet, m_sfe, 1'b0, m_bdf, 1'b0};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tbv = 0; m_busy = 0; m_txc = 0; m_rbv = 0; m_bdf = 0; m_sfe = 0;
        m_rxs = 0; m_prev = 1; m_tbd = '0; m_rbd = '0; m_sync = '1; m_wst = 0;
    endtask

    task automatic model_step();
        logic xfer, fend, last, fall, rise, wbrk;
        xfer = m_tbv && !m_busy;
        fend = i_txdone && m_busy;
        last = m_sync[SYNC-1];
        fall = m_prev && !last;
        rise = !m_prev && last;
        wbrk = (m_wst == 2) && rise;
        if (fend && !m_tbv && !i_txwr) m_txc = 1;
        else if (i_swr && i_swd[6])    m_txc = 0;
        if (xfer) m_busy = 1; else if (fend) m_busy = 0;
        if (i_txwr) begin m_tbv = 1; m_tbd = i_txd; end
        else if (xfer) m_tbv = 0;
        if (i_brk || wbrk) m_bdf = 1;
        else if ((i_swr && i_swd[1]) || (i_rxen && i_rxdone)) m_bdf = 0;
        if (!i_rxen) m_rbv = 0;
        else if (i_rxdone) m_rbv = 1;
        else if (i_rd) m_rbv = 0;
        if (i_rxen && i_rxdone) m_rbd = i_rxdat;
        if (i_serr) m_sfe = 1; else if (i_swr && i_swd[3]) m_sfe = 0;
        if (!i_sdet) m_rxs = 0;
        else if (i_sleep && fall) m_rxs = 1;
        else if (i_swr && i_swd[4]) m_rxs = 0;
        if (i_swr && i_swd[0]) m_wst = 1;
        else if (m_wst == 1 && !last) m_wst = 2;
        else if (m_wst == 2 && rise) m_wst = 0;
        m_prev = last;
        m_sync = {m_sync[SYNC-2:0], i_rxd};
    endtask

    task automatic check_all();
        logic [7:0] e;
        e = exp_status();
        chk("R2 receive-complete bit7", 32'(o_stat[7]), 32'(e[7]));
        chk("R2 receive data", 32'(o_rdata), 32'(m_rbd));
        chk("R6 transmit-complete bit6", 32'(o_stat[6]), 32'(e[6]));
        chk("R4 data-empty bit5", 32'(o_stat[5]), 32'(e[5]));
        chk("R8 receive-start bit4", 32'(o_stat[4]), 32'(e[4]));
        chk("R9 sync-error bit3", 32'(o_stat[3]), 32'(e[3]));
        chk("R10 break bit1", 32'(o_stat[1]), 32'(e[1]));
        chk("R7 reserved bits 2,0", 32'({o_stat[2], o_stat[0]}), 32'd0);
        chk("R12 irq", 32'(o_irq), 32'(|(e & i_ien)));
        chk("R5 shift_load", 32'(o_load), 32'(m_tbv && !m_busy));
        chk("R5 shift_data", 32'(o_shd), 32'(m_tbd));
        chk("R5 shift_busy", 32'(o_busy), 32'(m_busy));
    endtask

    // one clock: model advances with the held inputs, outputs compared after the edge
    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all();
        i_txwr = 0; i_rd = 0; i_swr = 0; i_txdone = 0; i_rxdone = 0;
        i_serr = 0; i_brk = 0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd77031);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 reset status", 32'(o_stat), 32'h20);
        chk("R1 reset irq", 32'(o_irq), 32'd0);
        check_all();

        // R4 / R5: write with idle shifter, then second write while busy
        i_txwr = 1; i_txd = 8'hA5; step();
        chk("R4 empty bit cleared by write", 32'(o_stat[5]), 32'd0);
        chk("R5 load offered", 32'(o_load), 32'd1);
        step();
        chk("R4 empty bit back after handoff", 32'(o_stat[5]), 32'd1);
        i_txwr = 1; i_txd = 8'h3C; step();
        i_txdone = 1; step();
        chk("R6 no complete while byte waits", 32'(o_stat[6]), 32'd0);
        step();
        i_txdone = 1; step();
        chk("R6 complete after last frame", 32'(o_stat[6]), 32'd1);
        i_swr = 1; i_swd = 8'h40; step();
        chk("R6 write-one clears", 32'(o_stat[6]), 32'd0);

        // R7: all-ones status write leaves bit5/bit7 alone
        i_swr = 1; i_swd = 8'hFF; step();
        chk("R7 status after all-ones write", 32'(o_stat), 32'h20);

        // R2 / R3: receive, flush by disable, ignore while disabled
        i_rxdone = 1; i_rxdat = 8'h5A; step();
        chk("R2 data held", 32'(o_rdata), 32'h5A);
        i_rxen = 0; step();
        chk("R3 flush on disable", 32'(o_stat[7]), 32'd0);
        i_rxdone = 1; i_rxdat = 8'h11; step();
        chk("R3 frame ignored", 32'(o_stat[7]), 32'd0);
        i_rxen = 1; step();

        // R8: falling edge during sleep
        i_sleep = 1; i_sdet = 1; i_rxd = 0;
        repeat (SYNC + 2) step();
        chk("R8 start flag set", 32'(o_stat[4]), 32'd1);
        i_rxd = 1; i_sdet = 0; step();
        chk("R8 start flag gated", 32'(o_stat[4]), 32'd0);
        i_sdet = 1; i_sleep = 0; step();

        // R11: armed break wait, low then high on the line
        i_swr = 1; i_swd = 8'h01; step();
        i_rxd = 0; repeat (SYNC + 2) step();
        chk("R11 no break before rise", 32'(o_stat[1]), 32'd0);
        i_rxd = 1; repeat (SYNC + 2) step();
        chk("R11 break after low-high", 32'(o_stat[1]), 32'd1);
        // R10: next accepted frame clears the break flag
        i_rxdone = 1; i_rxdat = 8'h77; step();
        chk("R10 cleared by frame", 32'(o_stat[1]), 32'd0);
        // R9
        i_serr = 1; step();
        chk("R9 set", 32'(o_stat[3]), 32'd1);
        i_swr = 1; i_swd = 8'h08; step();
        chk("R9 cleared", 32'(o_stat[3]), 32'd0);
        // R12 single enable
        i_ien = 8'h20; step();
        chk("R12 irq from empty bit", 32'(o_irq), 32'd1);

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            i_txwr   = ($urandom % 100) < 20;
            i_txd    = DW'($urandom);
            i_txdone = ($urandom % 100) < 25;
            i_rxdone = ($urandom % 100) < 15;
            i_rxdat  = DW'($urandom);
            i_rd     = ($urandom % 100) < 25;
            i_swr    = ($urandom % 100) < 8;
            i_swd    = 8'($urandom);
            i_serr   = ($urandom % 100) < 3;
            i_brk    = ($urandom % 100) < 3;
            if (($urandom % 100) < 3)  i_rxen  = ~i_rxen;
            if (($urandom % 100) < 5)  i_sleep = ~i_sleep;
            if (($urandom % 100) < 2)  i_sdet  = ~i_sdet;
            if (($urandom % 100) < 12) i_rxd   = ~i_rxd;
            if (($urandom % 100) < 5)  i_ien   = 8'($urandom);
            step();
        end

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscmp++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule